// File: doc/BRIEF.md
# Line-Region Sequence Pointer Selector

This block divides one field (the interval between two field-start strobes) into as many as four line regions. It does this separately for three timing signals: the optical-black clamp, pre-blanking and horizontal blanking. Each signal has its own three programmable change positions, given as line numbers, and its own four 2-bit sequence pointers. The first region always begins at line 0. For every line, the block reports which region each signal is in and which of four horizontal sequences that signal must use. A separate waveform generator reads these values.

An internal line counter follows the field. A field-start strobe returns it to line 0. Each line strobe advances it. Region and sequence outputs are registered and change only on those strobes, so they stay constant for the whole line. Configuration is expected to stay unchanged within a field. New values take effect cleanly from the next field-start strobe.

Top module: `seq_region_select`

## Requirements
- R1: While rst_n is low at a clock edge, every region output goes to 0 and every sequence output goes to 0.
- R2: A field-start strobe sets the line number to 0. On the next clock, every region output is 0 and every sequence output equals that signal's region-0 pointer. A field-start strobe wins over a line strobe in the same cycle.
- R3: Region and sequence outputs change only in the cycle after a line strobe or field-start strobe. In all other cycles they hold, even if the pointer inputs change.
- R4: The line number advances by one on each line strobe and saturates at 2^LINE_W-1. It does not wrap.
- R5: After a strobe, each signal's region is the highest accepted change position index whose line value is at or below the new line number. If no change position qualifies, the region is 0.
- R6: Change position k (k = 1..3, at bits [LINE_W*(k-1) +: LINE_W] of the signal's position port) is accepted only if it is strictly greater than the last accepted position. The starting value is line 0. A region whose position is not accepted is never entered, so a position of 0 is ignored.
- R7: Each sequence output equals the 2-bit pointer field of that signal's current region. The field for region k is at bits [2k+1:2k] of the signal's pointer port.
- R8: The three signals are independent: each signal's region and sequence depend only on its own position and pointer ports.
- R9: With configuration held steady, a signal's region never decreases on a line strobe within a field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle strobe at the start of a field |
| line_strobe | input | 1 | One-cycle strobe at the start of each line |
| clamp_cp | input | NUM_CP*LINE_W | Clamp change positions 1..NUM_CP |
| pblk_cp | input | NUM_CP*LINE_W | Pre-blanking change positions 1..NUM_CP |
| hblk_cp | input | NUM_CP*LINE_W | Horizontal-blanking change positions 1..NUM_CP |
| clamp_ptr | input | (NUM_CP+1)*PTR_W | Clamp sequence pointer per region |
| pblk_ptr | input | (NUM_CP+1)*PTR_W | Pre-blanking sequence pointer per region |
| hblk_ptr | input | (NUM_CP+1)*PTR_W | Horizontal-blanking sequence pointer per region |
| clamp_seq | output | PTR_W | Clamp sequence index for the current line |
| pblk_seq | output | PTR_W | Pre-blanking sequence index for the current line |
| hblk_seq | output | PTR_W | Horizontal-blanking sequence index for the current line |
| clamp_region | output | clog2(NUM_CP+1) | Clamp region of the current line |
| pblk_region | output | clog2(NUM_CP+1) | Pre-blanking region of the current line |
| hblk_region | output | clog2(NUM_CP+1) | Horizontal-blanking region of the current line |

## Verification
The bench builds the block with LINE_W = 6, NUM_CP = 3 and PTR_W = 2. With a 6-bit line counter, a field of 70 lines runs past the last line number. A change position at line 63 then shows whether the counter saturates or wraps back into region 0. Small line values also mean random change positions often collide or fall out of order, which exercises the skipped-region rule. The three signals carry different settings in every field, so any cross-wiring between them shows up.

// File: rtl/seq_region_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the line-region sequence pointer selector.
// Assumes a fixed set of three timing signals handled in parallel.
package seq_region_pkg;
    localparam int NUM_SIG = 3;
    typedef enum logic [1:0] {
        SIG_CLAMP = 2'd0,
        SIG_PBLK  = 2'd1,
        SIG_HBLK  = 2'd2
    } sig_e;
endpackage

// File: rtl/seq_line_counter.sv
`timescale 1ns/1ps
// Field line counter. Holds the current line number and offers the
// line number the next strobe will load (0 on field start, saturating
// increment otherwise). Assumes strobes are single-cycle pulses.
module seq_line_counter #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_strobe,
    output logic [LINE_W-1:0] cur_line,
    output logic [LINE_W-1:0] next_line
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    // Line number that the coming strobe will make current.
    always_comb begin
        if (field_start)
            next_line = '0;
        else if (cur_line == LINE_MAX)
            next_line = cur_line;
        else
            next_line = cur_line + 1'b1;
    end

    // Line register: cleared by reset or field start, loaded on line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_line <= '0;
        else if (field_start)
            cur_line <= '0;
        else if (line_strobe)
            cur_line <= next_line;
    end

    assert_field_clears_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> cur_line == '0);
    assert_line_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !field_start && cur_line != LINE_MAX) |=> cur_line == $past(cur_line) + 1'b1);
    assert_line_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !field_start && cur_line == LINE_MAX) |=> cur_line == LINE_MAX);
endmodule

// File: rtl/seq_region_decode.sv
`timescale 1ns/1ps
// Region decoder for one timing signal. Finds the region of the line
// about to start from the signal's change positions and registers the
// region and its pointer on each strobe. Assumes configuration is held
// steady within a field. A position not strictly above the last
// accepted one is ignored.
module seq_region_decode #(
    parameter int LINE_W = 12,
    parameter int NUM_CP = 3,
    parameter int PTR_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        field_start,
    input  logic                        line_strobe,
    input  logic [LINE_W-1:0]           next_line,
    input  logic [NUM_CP*LINE_W-1:0]    cp_flat,
    input  logic [(NUM_CP+1)*PTR_W-1:0] ptr_flat,
    output logic [$clog2(NUM_CP+1)-1:0] region,
    output logic [PTR_W-1:0]            seq
);
    localparam int REG_W = $clog2(NUM_CP+1);

    logic [LINE_W-1:0] last_ok;
    logic [LINE_W-1:0] cp_k;
    logic [REG_W-1:0]  pick;
    logic [PTR_W-1:0]  seq_pick;

    // Walk the change positions in order, keep the ascending ones, pick the last one reached.
    always_comb begin
        last_ok = '0;
        pick    = '0;
        cp_k    = '0;
        for (int k = 1; k <= NUM_CP; k++) begin
            cp_k = cp_flat[(k-1)*LINE_W +: LINE_W];
            if (cp_k > last_ok) begin
                last_ok = cp_k;
                if (cp_k <= next_line)
                    pick = REG_W'(k);
            end
        end
        seq_pick = ptr_flat[pick*PTR_W +: PTR_W];
    end

    // Output registers: forced to region 0 on field start, loaded on line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region <= '0;
            seq    <= '0;
        end else if (field_start) begin
            region <= '0;
            seq    <= ptr_flat[PTR_W-1:0];
        end else if (line_strobe) begin
            region <= pick;
            seq    <= seq_pick;
        end
    end

    assert_field_region0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (region == '0) && (seq == $past(ptr_flat[PTR_W-1:0])));
    assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_strobe && !field_start) |=> ($stable(region) && $stable(seq)));
    assert_region_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !field_start && $stable(cp_flat)) |=> region >= $past(region));
endmodule

// File: rtl/seq_region_select.sv
`timescale 1ns/1ps
// Top of the line-region sequence pointer selector. One shared line
// counter feeds one region decoder per timing signal (clamp,
// pre-blanking, horizontal blanking). Each decoder has its own positions
// and pointers. Assumes single-cycle strobes.
module seq_region_select #(
    parameter int LINE_W = 12,
    parameter int NUM_CP = 3,
    parameter int PTR_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        field_start,
    input  logic                        line_strobe,
    input  logic [NUM_CP*LINE_W-1:0]    clamp_cp,
    input  logic [NUM_CP*LINE_W-1:0]    pblk_cp,
    input  logic [NUM_CP*LINE_W-1:0]    hblk_cp,
    input  logic [(NUM_CP+1)*PTR_W-1:0] clamp_ptr,
    input  logic [(NUM_CP+1)*PTR_W-1:0] pblk_ptr,
    input  logic [(NUM_CP+1)*PTR_W-1:0] hblk_ptr,
    output logic [PTR_W-1:0]            clamp_seq,
    output logic [PTR_W-1:0]            pblk_seq,
    output logic [PTR_W-1:0]            hblk_seq,
    output logic [$clog2(NUM_CP+1)-1:0] clamp_region,
    output logic [$clog2(NUM_CP+1)-1:0] pblk_region,
    output logic [$clog2(NUM_CP+1)-1:0] hblk_region
);
    import seq_region_pkg::*;
    localparam int REG_W = $clog2(NUM_CP+1);

    logic [LINE_W-1:0]           cur_line;
    logic [LINE_W-1:0]           next_line;
    logic [NUM_CP*LINE_W-1:0]    cp_arr  [NUM_SIG];
    logic [(NUM_CP+1)*PTR_W-1:0] ptr_arr [NUM_SIG];
    logic [REG_W-1:0]            reg_arr [NUM_SIG];
    logic [PTR_W-1:0]            seq_arr [NUM_SIG];

    // Gather per-signal configuration into indexed arrays.
    always_comb begin
        cp_arr[SIG_CLAMP]  = clamp_cp;
        cp_arr[SIG_PBLK]   = pblk_cp;
        cp_arr[SIG_HBLK]   = hblk_cp;
        ptr_arr[SIG_CLAMP] = clamp_ptr;
        ptr_arr[SIG_PBLK]  = pblk_ptr;
        ptr_arr[SIG_HBLK]  = hblk_ptr;
    end

    seq_line_counter #(.LINE_W(LINE_W)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .line_strobe (line_strobe),
        .cur_line    (cur_line),
        .next_line   (next_line)
    );

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
        seq_region_decode #(.LINE_W(LINE_W), .NUM_CP(NUM_CP), .PTR_W(PTR_W)) u_dec (
            .clk         (clk),
            .rst_n       (rst_n),
            .field_start (field_start),
            .line_strobe (line_strobe),
            .next_line   (next_line),
            .cp_flat     (cp_arr[g]),
            .ptr_flat    (ptr_arr[g]),
            .region      (reg_arr[g]),
            .seq         (seq_arr[g])
        );
    end

    // Spread decoder results back onto the named output ports.
    always_comb begin
        clamp_region = reg_arr[SIG_CLAMP];
        pblk_region  = reg_arr[SIG_PBLK];
        hblk_region  = reg_arr[SIG_HBLK];
        clamp_seq    = seq_arr[SIG_CLAMP];
        pblk_seq     = seq_arr[SIG_PBLK];
        hblk_seq     = seq_arr[SIG_HBLK];
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (clamp_region == '0 && pblk_region == '0 && hblk_region == '0 &&
                    clamp_seq == '0 && pblk_seq == '0 && hblk_seq == '0));
endmodule

// File: tb/seq_region_select_test.sv
`timescale 1ns/1ps
module seq_region_select_test;
    localparam int LW = 6;
    localparam int NC = 3;
    localparam int PW = 2;
    localparam int LMAX = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_start = 1'b0;
    logic line_strobe = 1'b0;
    logic [NC*LW-1:0] clamp_cp, pblk_cp, hblk_cp;
    logic [(NC+1)*PW-1:0] clamp_ptr, pblk_ptr, hblk_ptr;
    logic [PW-1:0] clamp_seq, pblk_seq, hblk_seq;
    logic [1:0] clamp_region, pblk_region, hblk_region;

    logic [LW-1:0] cfg_cp  [3][1:3];
    logic [PW-1:0] cfg_ptr [3][4];

    int total = 0;
    int bad = 0;
    int ex_line = 0;
    bit rst_state = 1'b1;

    always #5 clk = ~clk;

    // Pack the bench configuration arrays onto the flat ports (R6, R7 field positions).
    always_comb begin
        for (int k = 1; k <= 3; k++) begin
            clamp_cp[(k-1)*LW +: LW] = cfg_cp[0][k];
            pblk_cp[(k-1)*LW +: LW]  = cfg_cp[1][k];
            hblk_cp[(k-1)*LW +: LW]  = cfg_cp[2][k];
        end
        for (int k = 0; k < 4; k++) begin
            clamp_ptr[k*PW +: PW] = cfg_ptr[0][k];
            pblk_ptr[k*PW +: PW]  = cfg_ptr[1][k];
            hblk_ptr[k*PW +: PW]  = cfg_ptr[2][k];
        end
    end

    seq_region_select #(.LINE_W(LW), .NUM_CP(NC), .PTR_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_strobe(line_strobe),
        .clamp_cp(clamp_cp), .pblk_cp(pblk_cp), .hblk_cp(hblk_cp),
        .clamp_ptr(clamp_ptr), .pblk_ptr(pblk_ptr), .hblk_ptr(hblk_ptr),
        .clamp_seq(clamp_seq), .pblk_seq(pblk_seq), .hblk_seq(hblk_seq),
        .clamp_region(clamp_region), .pblk_region(pblk_region), .hblk_region(hblk_region)
    );

    // Expected region: walk ascending accepted positions (R5, R6).
    function automatic int exp_region(int s, int line);
        int last = 0;
        int r = 0;
        for (int k = 1; k <= 3; k++) begin
            if (int'(cfg_cp[s][k]) > last) begin
                last = int'(cfg_cp[s][k]);
                if (last <= line) r = k;
            end
        end
        return r;
    endfunction

    int exp_reg [3];
    int exp_seq [3];

    task automatic model_update();
        for (int s = 0; s < 3; s++) begin
            if (rst_state) begin
                exp_reg[s] = 0;
                exp_seq[s] = 0;
            end else begin
                exp_reg[s] = exp_region(s, ex_line);
                exp_seq[s] = int'(cfg_ptr[s][exp_reg[s]]);
            end
        end
    endtask

    task automatic check_all(string tag);
        int ar, as_;
        for (int s = 0; s < 3; s++) begin
            case (s)
                0: begin ar = int'(clamp_region); as_ = int'(clamp_seq); end
                1: begin ar = int'(pblk_region);  as_ = int'(pblk_seq);  end
                default: begin ar = int'(hblk_region); as_ = int'(hblk_seq); end
            endcase
            total++;
            if (ar != exp_reg[s] || as_ != exp_seq[s]) begin
                bad++;
                $display("FAIL %s R5/R7 sig%0d line%0d: region=%0d seq=%0d expected region=%0d seq=%0d",
                         tag, s, ex_line, ar, as_, exp_reg[s], exp_seq[s]);
            end
        end
    endtask

    // One strobe cycle; outputs sampled on the following falling edge.
    task automatic pulse(bit fs, bit ls, string tag);
        @(negedge clk);
        field_start = fs;
        line_strobe = ls;
        @(negedge clk);
        field_start = 1'b0;
        line_strobe = 1'b0;
        if (fs) ex_line = 0;
        else if (ls && ex_line < LMAX) ex_line++;
        model_update();
        check_all(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_sig(int s, int c1, int c2, int c3, int p0, int p1, int p2, int p3);
        cfg_cp[s][1] = LW'(c1); cfg_cp[s][2] = LW'(c2); cfg_cp[s][3] = LW'(c3);
        cfg_ptr[s][0] = PW'(p0); cfg_ptr[s][1] = PW'(p1);
        cfg_ptr[s][2] = PW'(p2); cfg_ptr[s][3] = PW'(p3);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [PW-1:0] saved;
        void'($urandom(32'd4242));
        set_sig(0, 5, 10, 20, 1, 2, 3, 0);
        set_sig(1, 0, 8, 8, 3, 1, 2, 0);     // R6: cp1=0 and equal cp3 ignored
        set_sig(2, 30, 12, 40, 2, 3, 0, 1);  // R6: cp2 below cp1 ignored
        // R1: reset state
        idle(3);
        model_update();
        check_all("R1 reset");
        rst_n = 1'b1;
        idle(2);
        check_all("R1 after release, no strobe");

        // R2 field start, then directed field covering R5, R6, R8
        pulse(1'b1, 1'b0, "R2 field start");
        for (int i = 0; i < 45; i++) begin
            pulse(1'b0, 1'b1, "R5 R6 R8 directed field");
            if (i % 7 == 3) begin
                idle(2);
                check_all("R3 idle gap");
            end
        end

        // R3: pointer change without strobe leaves outputs unchanged
        saved = cfg_ptr[0][3];
        cfg_ptr[0][3] = ~saved;
        cfg_ptr[1][0] = ~cfg_ptr[1][0];
        idle(3);
        check_all("R3 pointer change ignored");
        cfg_ptr[0][3] = saved;
        cfg_ptr[1][0] = ~cfg_ptr[1][0];
        idle(1);

        // R2: field start wins over a simultaneous line strobe
        pulse(1'b1, 1'b1, "R2 priority over line strobe");
        pulse(1'b0, 1'b1, "R2 first line after field start");

        // R4: saturation; clamp region 3 at line 63 must persist past 63
        set_sig(0, 20, 40, 63, 0, 1, 2, 3);
        pulse(1'b1, 1'b0, "R4 field start");
        for (int i = 0; i < 70; i++) pulse(1'b0, 1'b1, "R4 saturate R9");
        total++;
        if (clamp_region != 2'd3) begin
            bad++;
            $display("FAIL R4 saturated region=%0d expected=3", clamp_region);
        end

        // Random fields: R5 R6 R7 R8 R9
        for (int f = 0; f < 25; f++) begin
            int nlines;
            for (int s = 0; s < 3; s++) begin
                for (int k = 1; k <= 3; k++) cfg_cp[s][k] = LW'($urandom_range(0, 50));
                for (int k = 0; k < 4; k++) cfg_ptr[s][k] = PW'($urandom_range(0, 3));
            end
            idle(1);
            pulse(1'b1, 1'b0, "R2 random field start");
            nlines = $urandom_range(10, 60);
            for (int i = 0; i < nlines; i++) begin
                idle($urandom_range(0, 2));
                pulse(1'b0, 1'b1, "R5 R6 R7 R8 random");
            end
        end

        // R1: reset mid-field
        @(negedge clk);
        rst_n = 1'b0;
        rst_state = 1'b1;
        @(negedge clk);
        model_update();
        check_all("R1 mid-field reset");
        rst_n = 1'b1;
        rst_state = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // rst_state tracks the bench's knowledge of reset for the model.
    initial begin
        @(negedge clk);
        wait (rst_n);
        rst_state = 1'b0;
    end
endmodule